// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous static memory whose bidirectional data bus is split into a write-data input, a read-data output and an output-enable. Commands are taken on every enabled rising clock edge. A read command returns its word in the same cycle, right after the capturing edge, with no output register. A write command supplies its data one cycle later. Because of that lag, reads and writes can follow each other in any mix without idle cycles.

A write is held in a posted-write register once its data arrives. It is committed to the array on the next enabled edge. A read that hits the posted address gets the posted lanes merged over the array word.

Each word is made of byte lanes, and each lane has its own active-low write select. Three chip selects of mixed polarity qualify a new command. A run enable freezes the whole pipeline. A two-bit burst sequencer steps through a group of four words in linear or interleaved order, chosen by a static mode pin.

Top module: `ftsram_top`

## Requirements
- R1: A read command captured at an enabled edge drives the addressed word on `rdata` with `rdata_vld` high during the cycle that follows that same edge.
- R2: Write data is taken from `wdata` at the enabled edge after the write command. Lane selects are taken with the command; a low `lane_wr_n[i]` writes bits `[9*i+8:9*i]` and a high one leaves that lane unchanged.
- R3: Reads and writes may be issued on consecutive enabled edges in any order. A read issued right after a write to the same address returns the newly written lanes merged over the old word.
- R4: A new command is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination makes a deselect cycle, which writes nothing and keeps `rdata_vld` low.
- R5: An edge with `run_en`=0 is ignored. Command state, pending write and outputs hold, and the `wdata`, `addr` and control values present at that edge have no effect.
- R6: In the cycle after a write command, `rdata_vld` is low whatever the value of `oe_n`.
- R7: `oe_n` acts combinationally on `rdata_vld`/`rdata` only. Toggling it changes no stored state.
- R8: With `adv`=1 the prior command continues. With `order_ilv`=0 the two low address bits become (start + k) mod 4 at beat k, and the upper address bits stay unchanged.
- R9: With `order_ilv`=1 the two low address bits at beat k are start XOR k.
- R10: After reset no command is active, no write is pending and `rdata_vld` is low.
- R11: A continuation inherits read/write type and selection from the loaded command. During a continuation, `wr_n` and the chip selects are ignored and lane selects are sampled fresh. A continuation of a deselect stays deselected.
- R12: `rdata` is all zeros whenever `rdata_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = process this edge, 0 = freeze |
| addr | input | ADDR_W | Word address for a loaded command |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write command, 1 = read command |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| adv | input | 1 | 0 = load new command, 1 = continue burst |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | LANES*LANE_W | Write data, one cycle after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
Full-word writes fill every address back to back, and every address is then read back. This separates a correct array path from addressing faults. Each address then takes a write with each of the four lane masks, followed at once by a read of the same word; a bad merge or lane swap in the posted-write bypass shows up only in this pattern. Linear and interleaved bursts from all four start offsets, deselect combinations, and stalls placed between a write command and its data tell apart the sequencer, the select decode and the pipeline freeze. A long random mix against an arithmetic memory model covers the orderings that the directed sweeps miss.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int BURST_W = 2;

  // low address bits for beat 'step' of a burst starting at 'start'
  function automatic logic [BURST_W-1:0] burst_low(input logic [BURST_W-1:0] start,
                                                   input logic [BURST_W-1:0] step,
                                                   input logic ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/ftsram_mem.sv
module ftsram_mem #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wr_lanes[g]) begin
        bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/ftsram_cmd_stage.sv
module ftsram_cmd_stage
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              adv,
  input  logic              order_ilv,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  lanes_o
);
  op_e                 op_q, op_d;
  logic [ADDR_W-1:0]   base_q, base_d;
  logic [BURST_W-1:0]  cnt_q, cnt_d;
  logic [LANES-1:0]    lanes_q, lanes_d;
  logic                sel;

  assign sel = ~cs0_n & cs1 & ~cs2_n;

  always_comb begin
    op_d    = op_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    lanes_d = lanes_q;
    if (run_en) begin
      lanes_d = ~lane_wr_n;
      if (!adv) begin
        op_d   = !sel ? OP_NONE : (wr_n ? OP_READ : OP_WRITE);
        base_d = addr;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      base_q  <= '0;
      cnt_q   <= '0;
      lanes_q <= '0;
    end else begin
      op_q    <= op_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      lanes_q <= lanes_d;
    end
  end

  assign op_o    = op_q;
  assign lanes_o = lanes_q;
  assign addr_o  = {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_q, order_ilv)};

  // R4
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !adv && !(!cs0_n && cs1 && !cs2_n)) |=> (op_o == OP_NONE));

  // R5
  cmd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en) |=> ($stable(op_o) && $stable(lanes_o)));

  // R8
  burst_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && adv) |=> $stable(addr_o[ADDR_W-1:BURST_W]));

  // R11
  burst_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && adv) |=> $stable(op_o));
endmodule

// File: rtl/ftsram_post_wr.sv
module ftsram_post_wr
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  op_e                     cmd_op,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES-1:0]        cmd_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] arr_word,
  output logic                    commit_en,
  output logic [ADDR_W-1:0]       commit_addr,
  output logic [LANES-1:0]        commit_lanes,
  output logic [LANES*LANE_W-1:0] commit_data,
  output logic [LANES*LANE_W-1:0] merged
);
  localparam int DATA_W = LANES * LANE_W;

  logic              pv_q, pv_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [LANES-1:0]  pl_q, pl_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic              hit;

  always_comb begin
    pv_d = pv_q;
    pa_d = pa_q;
    pl_d = pl_q;
    pd_d = pd_q;
    if (run_en) begin
      pv_d = (cmd_op == OP_WRITE);
      if (cmd_op == OP_WRITE) begin
        pa_d = cmd_addr;
        pl_d = cmd_lanes;
        pd_d = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pa_q <= '0;
      pl_q <= '0;
      pd_q <= '0;
    end else begin
      pv_q <= pv_d;
      pa_q <= pa_d;
      pl_q <= pl_d;
      pd_q <= pd_d;
    end
  end

  assign commit_en    = run_en & pv_q;
  assign commit_addr  = pa_q;
  assign commit_lanes = pl_q;
  assign commit_data  = pd_q;
  assign hit          = pv_q && (pa_q == cmd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (hit && pl_q[g]) ? pd_q[g*LANE_W +: LANE_W]
                                                         : arr_word[g*LANE_W +: LANE_W];
  end

  // R2
  post_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cmd_op == OP_WRITE) |=> (pv_q && pd_q == $past(wdata)));

  // R5
  post_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en) |=> ($stable(pv_q) && $stable(pd_q) && $stable(pa_q)));
endmodule

// File: rtl/ftsram_top.sv
module ftsram_top
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    adv,
  input  logic                    order_ilv,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_lanes;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_lanes;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] merged;

  ftsram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) cmd_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .addr(addr),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .adv(adv), .order_ilv(order_ilv),
    .op_o(cmd_op), .addr_o(cmd_addr), .lanes_o(cmd_lanes)
  );

  ftsram_post_wr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) post_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_lanes(cmd_lanes), .wdata(wdata),
    .arr_word(arr_word), .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_lanes(commit_lanes), .commit_data(commit_data), .merged(merged)
  );

  ftsram_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) mem_i (
    .clk(clk), .we(commit_en), .wr_addr(commit_addr), .wr_lanes(commit_lanes),
    .wr_data(commit_data), .rd_addr(cmd_addr), .rd_data(arr_word)
  );

  assign rdata_vld = (cmd_op == OP_READ) & ~oe_n;
  assign rdata     = rdata_vld ? merged : '0;

  // R6
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !adv && !cs0_n && cs1 && !cs2_n && !wr_n) |=> !rdata_vld);

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_vld);

  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_vld |-> (rdata == '0));
endmodule

// File: tb/ftsram_top_tb_top.sv
module ftsram_top_tb_top;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run_en, cs0_n, cs1, cs2_n, wr_n, adv, order_ilv, oe_n;
  logic [AW-1:0] addr;
  logic [1:0]    lane_wr_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_vld;

  int total = 0;
  int bad = 0;

  // bench model
  logic [DW-1:0] mdl [DEPTH];
  int            m_op;       // 0 none, 1 read, 2 write
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic [AW-1:0] m_eff;
  logic          m_pend;
  logic [AW-1:0] m_paddr;
  logic [1:0]    m_plane;

  ftsram_top #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .addr(addr),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .adv(adv), .order_ilv(order_ilv),
    .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input string req);
    logic ev;
    ev = (m_op == 1) && !oe_n;
    chk(req, {17'd0, rdata_vld}, {17'd0, ev});
    chk(req, rdata, ev ? mdl[m_eff] : '0);
  endtask

  // one clock: model update at the edge, check mid-cycle, return at negedge
  task automatic tick(input string req);
    @(posedge clk);
    if (run_en) begin
      if (m_pend) begin
        if (m_plane[0]) mdl[m_paddr][8:0]  = wdata[8:0];
        if (m_plane[1]) mdl[m_paddr][17:9] = wdata[17:9];
        m_pend = 1'b0;
      end
      if (!adv) begin
        m_op   = (!cs0_n && cs1 && !cs2_n) ? (wr_n ? 1 : 2) : 0;
        m_base = addr;
        m_cnt  = 2'd0;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      m_eff = {m_base[AW-1:2], order_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      if (m_op == 2) begin
        m_pend  = 1'b1;
        m_paddr = m_eff;
        m_plane = ~lane_wr_n;
      end
    end
    #5;
    check_out(req);
    @(negedge clk);
  endtask

  task automatic load(input logic sel, input logic wr, input logic [AW-1:0] a, input logic [1:0] ln);
    run_en = 1'b1; adv = 1'b0;
    cs0_n = !sel; cs1 = sel; cs2_n = !sel;
    wr_n = !wr; addr = a; lane_wr_n = ln;
    wdata = DW'($urandom);
  endtask

  task automatic cont(input logic [1:0] ln);
    run_en = 1'b1; adv = 1'b1;
    cs0_n = $urandom % 2; cs1 = $urandom % 2; cs2_n = $urandom % 2;
    wr_n = $urandom % 2; addr = AW'($urandom);
    lane_wr_n = ln;
    wdata = DW'($urandom);
  endtask

  initial begin
    rst_n = 1'b0; run_en = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    wr_n = 1'b1; adv = 1'b0; order_ilv = 1'b0; oe_n = 1'b0;
    addr = '0; lane_wr_n = 2'b11; wdata = '0;
    m_op = 0; m_base = '0; m_cnt = '0; m_eff = '0; m_pend = 1'b0;
    m_paddr = '0; m_plane = '0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {17'd0, rdata_vld}, 18'd0);
    chk("R10", rdata, 18'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R6: back-to-back full writes to every address
    for (int i = 0; i < DEPTH; i++) begin
      load(1'b1, 1'b1, AW'(i), 2'b00);
      tick("R6");
    end
    // R1: read every address back, first one right after last write (R3)
    for (int i = 0; i < DEPTH; i++) begin
      load(1'b1, 1'b0, AW'(i), 2'b11);
      tick("R1");
    end

    // R3 / R2: write with each lane mask, read same address at once
    for (int i = 0; i < DEPTH; i++) begin
      for (int m = 0; m < 4; m++) begin
        load(1'b1, 1'b1, AW'(i), 2'(m));
        tick("R2");
        load(1'b1, 1'b0, AW'(i), 2'b11);
        tick("R3");
      end
    end

    // R4: every non-selecting combination, with write, then read back
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) begin
        run_en = 1'b1; adv = 1'b0; wr_n = 1'b0; addr = AW'(5); lane_wr_n = 2'b00;
        {cs0_n, cs1, cs2_n} = 3'(c);
        wdata = DW'($urandom);
        tick("R4");
        load(1'b1, 1'b0, AW'(5), 2'b11);
        tick("R4");
      end
    end

    // R5: stall between write command and its data, then stall during read
    load(1'b1, 1'b1, AW'(9), 2'b00);
    tick("R5");
    run_en = 1'b0; wdata = DW'($urandom); adv = 1'b0; wr_n = 1'b1; addr = AW'(2);
    {cs0_n, cs1, cs2_n} = 3'b010;
    tick("R5");
    tick("R5");
    load(1'b1, 1'b0, AW'(9), 2'b11);
    tick("R5");
    run_en = 1'b0; wr_n = 1'b0; addr = AW'(1); wdata = DW'($urandom);
    tick("R5");
    tick("R5");

    // R7: asynchronous output enable within a read cycle
    load(1'b1, 1'b0, AW'(7), 2'b11);
    tick("R7");
    oe_n = 1'b1; #1;
    chk("R7", {17'd0, rdata_vld}, 18'd0);
    chk("R7", rdata, 18'd0);
    oe_n = 1'b0; #1;
    chk("R7", {17'd0, rdata_vld}, 18'd1);
    chk("R7", rdata, mdl[7]);
    @(negedge clk);
    run_en = 1'b0; oe_n = 1'b1;
    tick("R7");
    oe_n = 1'b0;
    tick("R7");

    // R8 / R9 / R11: write bursts then read bursts, every start offset
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        order_ilv = o[0];
        load(1'b1, 1'b1, AW'(4 + s), 2'($urandom));
        tick(o ? "R9" : "R8");
        for (int k = 0; k < 3; k++) begin
          cont(2'($urandom));
          tick("R11");
        end
        load(1'b1, 1'b0, AW'(4 + s), 2'b11);
        tick(o ? "R9" : "R8");
        for (int k = 0; k < 3; k++) begin
          cont(2'b11);
          tick(o ? "R9" : "R8");
        end
      end
    end
    // R11: continuation of a deselect stays deselected
    load(1'b0, 1'b1, AW'(8), 2'b00);
    tick("R11");
    for (int k = 0; k < 3; k++) begin
      cont(2'b00);
      tick("R11");
    end
    for (int i = 8; i < 12; i++) begin
      load(1'b1, 1'b0, AW'(i), 2'b11);
      tick("R11");
    end

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      if (n % 1000 == 0) begin
        load(1'b1, 1'b0, AW'(0), 2'b11);
        order_ilv = $urandom % 2;
        tick("R3");
      end
      run_en = ($urandom % 8) != 0;
      adv = ($urandom % 4) == 0;
      {cs0_n, cs1, cs2_n} = (($urandom % 6) == 0) ? 3'($urandom) : 3'b010;
      wr_n = $urandom % 2;
      lane_wr_n = 2'($urandom);
      addr = AW'($urandom);
      wdata = DW'($urandom);
      oe_n = ($urandom % 10) == 0;
      tick("R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule